// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small 8-bit processor core and decides which interrupt the core should take next. Two external pins and a set of peripheral event lines feed it. Edge-type events are held in pending flags. A pin set to level sensing raises a request only while it is held low. Each source has its own enable, and a global enable gates all of them. The pending, enabled source with the lowest index is offered to the core, together with its vector word address.

The core takes an interrupt by pulsing `irq_ack`. In that same cycle the controller clears the global enable and the flag of the source being serviced. A `reti` pulse from the core sets the global enable again. Software can also write the global enable directly. A small register port gives access to the external-request mask, the sense-control settings and two write-one-to-clear flag registers.

Top module: `intc_vec_ctrl`

## Requirements
- R1: After reset the global enable, mask register, sense settings and all flags are 0, and `irq_req` is 0.
- R2: In the mask register (`reg_sel`=0), bit 7 enables external request 1 and bit 6 enables external request 0. Bits 5..0 always read 0.
- R3: The sense control (`reg_sel`=2) uses bits 1..0 for pin 0 and bits 3..2 for pin 1. Code 11 latches a flag on a rising edge and code 10 on a falling edge. A flag appears three clock edges after the pin changes, because of the two-flop synchronizer. Flags read in `reg_sel`=1 as bit 6 (pin 0) and bit 7 (pin 1).
- R4: Code 01 is reserved: pin activity produces no flag and no request.
- R5: Code 00 is low-level sensing. A request is present only while the synchronized pin is low, and no flag is set.
- R6: An event that arrives while its enable or the global enable is 0 still sets its flag. The flag stays set until it is serviced or cleared.
- R7: Among enabled pending sources, the lowest index wins. Vectors are: pin 0 → 1, pin 1 → 2, peripheral k → 3+k.
- R8: `irq_ack` clears the global enable and the flag of the selected source, and leaves every other flag unchanged.
- R9: `reti` sets the global enable in the cycle after the pulse.
- R10: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. The peripheral flags are in `reg_sel`=3, bit k. A set and a clear in the same cycle leave the flag set.
- R11: `irq_req` is high exactly when the global enable is 1 and at least one enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | External request pins |
| periph_evt | input | NUM_PERIPH | Peripheral event pulses |
| periph_en | input | NUM_PERIPH | Per-peripheral enables |
| gie_wr | input | 1 | Software write strobe for the global enable |
| gie_wdata | input | 1 | Value for the global enable write |
| irq_ack | input | 1 | Core takes the offered vector |
| reti | input | 1 | Return-from-interrupt pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| gie | output | 1 | Global enable state |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector word address |

## Verification
Each pin is driven with a rising edge, a falling edge and a held low level, under each sense code. This separates edge latching from level following, and both from the reserved code. Several flags are raised together while the global enable is 0 and then serviced one by one. That sequence shows the priority order, that each acknowledge clears only one flag, and the hand-off between `irq_ack` and `reti`. Mask writes with all ones, write-one-to-clear writes of zeros, and a set colliding with a clear cover the register corner cases.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_EXTFL = 2'd1,
    SEL_SENSE = 2'd2,
    SEL_PERFL = 2'd3
  } regsel_e;

  localparam int EXT_N = 2;
endpackage

// File: rtl/intc_pin_sense.sv
module intc_pin_sense
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       lvl_req,
  output logic       edge_hit
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    rise     = s2_q & ~s3_q;
    fall     = ~s2_q & s3_q;
    lvl_req  = (sense_e'(mode) == SENSE_LOW) & ~s2_q;
    edge_hit = ((sense_e'(mode) == SENSE_RISE) & rise) |
               ((sense_e'(mode) == SENSE_FALL) & fall);
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int N = 6,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  active,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (active[i]) begin
        any    = 1'b1;
        idx    = IW'(i);
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_vec_ctrl.sv
module intc_vec_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int VEC_W      = 8,
  localparam int NUM_SRC   = EXT_N + NUM_PERIPH,
  localparam int IW        = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            ext_pin,
  input  logic [NUM_PERIPH-1:0] periph_evt,
  input  logic [NUM_PERIPH-1:0] periph_en,
  input  logic                  gie_wr,
  input  logic                  gie_wdata,
  input  logic                  irq_ack,
  input  logic                  reti,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_sel,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  output logic                  gie,
  output logic                  irq_req,
  output logic [VEC_W-1:0]      irq_vec
);
  logic rs1_q, rst_q;
  logic gie_q, gie_d;
  logic [1:0] mask_q, mask_d;
  logic [3:0] sense_q, sense_d;
  logic [NUM_SRC-1:0] flg_q, flg_d, set_v, clr_v, w1c_v, pend, en_v, active, pick_oh;
  logic [1:0] lvl_v, edge_v, is_lvl;
  logic pick_any;
  logic [IW-1:0] pick_idx;
  logic ctl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_q <= rs1_q;
    end
  end

  for (genvar g = 0; g < EXT_N; g++) begin : g_pin
    intc_pin_sense u_sense (
      .clk      (clk),
      .rst_n    (rst_q),
      .pin      (ext_pin[g]),
      .mode     (sense_q[2*g+1:2*g]),
      .lvl_req  (lvl_v[g]),
      .edge_hit (edge_v[g])
    );
    assign is_lvl[g] = (sense_e'(sense_q[2*g+1:2*g]) == SENSE_LOW);
  end

  intc_prio_pick #(.N(NUM_SRC)) u_pick (
    .active (active),
    .any    (pick_any),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  always_comb begin
    set_v = {periph_evt, edge_v};
    w1c_v = '0;
    if (reg_wr && regsel_e'(reg_sel) == SEL_EXTFL)
      w1c_v[1:0] = {reg_wdata[7], reg_wdata[6]};
    if (reg_wr && regsel_e'(reg_sel) == SEL_PERFL)
      w1c_v[NUM_SRC-1:EXT_N] = reg_wdata[NUM_PERIPH-1:0];
    clr_v = w1c_v | (irq_ack ? pick_oh : '0);
    flg_d = (flg_q & ~clr_v) | set_v;

    pend        = flg_q;
    pend[1:0]   = (is_lvl & lvl_v) | (~is_lvl & flg_q[1:0]);
    en_v        = {periph_en, mask_q};
    active      = pend & en_v;

    mask_d  = mask_q;
    sense_d = sense_q;
    if (reg_wr && regsel_e'(reg_sel) == SEL_MASK)  mask_d  = reg_wdata[7:6];
    if (reg_wr && regsel_e'(reg_sel) == SEL_SENSE) sense_d = reg_wdata[3:0];

    gie_d = gie_q;
    if (irq_ack)     gie_d = 1'b0;
    else if (reti)   gie_d = 1'b1;
    else if (gie_wr) gie_d = gie_wdata;
    ctl_en = reg_wr | irq_ack | reti | gie_wr;

    case (regsel_e'(reg_sel))
      SEL_MASK:  reg_rdata = {mask_q, 6'b0};
      SEL_EXTFL: reg_rdata = {flg_q[1], flg_q[0], 6'b0};
      SEL_SENSE: reg_rdata = {4'b0, sense_q};
      default:   reg_rdata = 8'(flg_q[NUM_SRC-1:EXT_N]);
    endcase

    gie     = gie_q;
    irq_req = gie_q & pick_any;
    irq_vec = VEC_W'(pick_idx) + VEC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      flg_q   <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      gie_q   <= 1'b0;
    end else begin
      flg_q <= flg_d;
      if (ctl_en) begin
        mask_q  <= mask_d;
        sense_q <= sense_d;
        gie_q   <= gie_d;
      end
    end
  end
endmodule

// File: rtl/intc_vec_ctrl_chk.sv
module intc_vec_ctrl_chk #(
  parameter int NUM_PERIPH = 4,
  parameter int VEC_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_ack,
  input logic             reti,
  input logic             gie_wr,
  input logic             reg_wr,
  input logic [1:0]       reg_sel,
  input logic [7:0]       reg_rdata,
  input logic             gie,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec
);
  localparam int NSRC = 2 + NUM_PERIPH;

  p_ack_clears_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !gie);

  p_reti_sets_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_ack) |=> gie);

  p_req_needs_gie_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie);

  p_vec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= VEC_W'(1) && irq_vec <= VEC_W'(NSRC)));

  p_mask_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (reg_rdata[5:0] == 6'd0));

  p_gie_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_ack && !reti && !gie_wr) |=> $stable(gie));
endmodule

bind intc_vec_ctrl intc_vec_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .irq_ack   (irq_ack),
  .reti      (reti),
  .gie_wr    (gie_wr),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .gie       (gie),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec)
);

// File: tb/sim_intc_vec_ctrl.sv
module sim_intc_vec_ctrl;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ext_pin = 2'b11;
  logic [NP-1:0] periph_evt = '0, periph_en = '0;
  logic gie_wr = 0, gie_wdata = 0, irq_ack = 0, reti = 0, reg_wr = 0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic gie, irq_req;
  logic [7:0] irq_vec;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intc_vec_ctrl #(.NUM_PERIPH(NP), .VEC_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .periph_evt(periph_evt),
    .periph_en(periph_en), .gie_wr(gie_wr), .gie_wdata(gie_wdata),
    .irq_ack(irq_ack), .reti(reti), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel; #0.1; d = reg_rdata;
  endtask

  task automatic set_gie(logic v);
    gie_wr = 1; gie_wdata = v; tick(); gie_wr = 0;
  endtask

  task automatic pulse_ack(); irq_ack = 1; tick(); irq_ack = 0; endtask
  task automatic pulse_reti(); reti = 1; tick(); reti = 0; endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 mask", d, 8'h00);
    rd(2'd1, d); chk("R1 extflags", d, 8'h00);
    rd(2'd2, d); chk("R1 sense", d, 8'h00);
    chk("R1 gie", gie, 0);
    chk("R1 irq_req", irq_req, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 mask all ones", d, 8'hC0);
    wr(2'd0, 8'h40); rd(2'd0, d); chk("R2 mask ext0 only", d, 8'h40);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    wr(2'd2, 8'h0B);              // pin1 falling (10), pin0 rising (11)
    ext_pin = 2'b00; tick(3);     // pin0 falls, pin1 falls
    rd(2'd1, d); chk("R3 falling edge pin1 only", d, 8'h80);
    ext_pin = 2'b11; tick(3);
    rd(2'd1, d); chk("R3 rising edge pin0", d, 8'hC0);
    chk("R6 masked flags no req", irq_req, 0);
    wr(2'd1, 8'hC0);
    rd(2'd1, d); chk("R10 w1c both", d, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    wr(2'd2, 8'h05); wr(2'd0, 8'hC0); set_gie(1);
    ext_pin = 2'b00; tick(3);
    rd(2'd1, d); chk("R4 reserved no flag", d, 8'h00);
    chk("R4 reserved no req", irq_req, 0);
    ext_pin = 2'b11; tick(3);
    chk("R4 reserved rise no req", irq_req, 0);
    set_gie(0); wr(2'd0, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(2'd2, 8'h04); wr(2'd0, 8'h40); set_gie(1); // pin0 level
    ext_pin[0] = 0; tick(2);
    chk("R5 level req", irq_req, 1);
    chk("R7 level vector pin0", irq_vec, 1);
    rd(2'd1, d); chk("R5 level no flag", d, 8'h00);
    ext_pin[0] = 1; tick(2);
    chk("R5 level released", irq_req, 0);
    set_gie(0); wr(2'd0, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(2'd2, 8'h0F); wr(2'd0, 8'hC0); periph_en = '1;
    ext_pin = 2'b00; tick(3); ext_pin = 2'b11; tick(3);
    periph_evt = 4'b0010; tick(); periph_evt = '0;
    chk("R11 gie off no req", irq_req, 0);
    rd(2'd3, d); chk("R6 periph flag latched", d, 8'h02);
    set_gie(1);
    chk("R11 req with gie", irq_req, 1);
    chk("R7 first vector", irq_vec, 1);
    pulse_ack();
    chk("R8 ack clears gie", gie, 0);
    rd(2'd1, d); chk("R8 only pin0 flag cleared", d, 8'h80);
    chk("R11 no req after ack", irq_req, 0);
    pulse_reti();
    chk("R9 reti sets gie", gie, 1);
    chk("R7 second vector", irq_vec, 2);
    pulse_ack(); pulse_reti();
    chk("R7 periph1 vector", irq_vec, 4);
    pulse_ack();
    rd(2'd3, d); chk("R8 periph flag cleared", d, 8'h00);
    pulse_reti();
    chk("R11 idle after all serviced", irq_req, 0);
    set_gie(0); wr(2'd0, 8'h00);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    periph_evt = 4'b0101; tick(); periph_evt = '0;
    wr(2'd3, 8'h00); rd(2'd3, d); chk("R10 write zero keeps", d, 8'h05);
    wr(2'd3, 8'h01); rd(2'd3, d); chk("R10 clear bit0", d, 8'h04);
    reg_sel = 2'd3; reg_wdata = 8'h04; reg_wr = 1; periph_evt = 4'b0100;
    tick(); reg_wr = 0; periph_evt = '0;
    rd(2'd3, d); chk("R10 set wins over clear", d, 8'h04);
    wr(2'd3, 8'hFF); rd(2'd3, d); chk("R10 clear all", d, 8'h00);
  endtask

  initial begin
    tick(2); rst_n = 1; tick(4);
    t_reset();
    t_mask();
    t_edges();
    t_reserved();
    t_level();
    t_priority();
    t_w1c();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished"); end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule